// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small fully-associative store placed between a direct-mapped first-level cache and the path that refills that cache from the next memory level. When the main cache misses, it presents the missing line address together with the line it is about to overwrite. Every buffer entry compares its full line address against the lookup in the same cycle. A match returns the line one cycle later. On a match, the displaced line takes the matching entry's slot, so the two lines trade places. Without a match, the block asks the next level for the line and keeps the displaced line. The line that was asked for is not kept.

A parameter selects a second mode. In that mode, the buffer keeps a copy of each line fetched from the next level instead of the displaced line. A hit then leaves the entry in place. In both modes the slot to fill is the lowest-numbered empty entry, or the least recently used entry when none is empty.

Top module: `conflict_victim_buf`

## Requirements
- R1: After reset every entry is empty, `lk_ready` is 1, and `fill_valid` and `mem_req` are 0.
- R2: A lookup hits only when a valid entry holds exactly the same `ADDR_W`-bit line address. No two valid entries ever hold the same address.
- R3: A hitting lookup gives `fill_valid`=1 and `fill_hit`=1 on the cycle after it is accepted, with the entry's data. No memory request is issued for it.
- R4: A missing lookup raises `mem_req` for exactly one cycle on the cycle after acceptance, with `mem_req_addr` equal to the lookup address. `lk_ready` stays 0 until the response is taken. The cycle after `mem_rsp_valid` is taken, `fill_valid`=1, `fill_hit`=0 and the data is the response data. A response is taken only when `lk_ready` is 0 and `mem_req` is 0.
- R5: In displaced-line mode (`CAPTURE_REQ`=0), a miss with `dsp_valid`=1 stores the displaced line. The requested line is not stored, so a repeat lookup of it misses.
- R6: A displaced line presented with `dsp_valid`=0 is never stored.
- R7: In displaced-line mode, a hit puts the displaced line into the hit entry's slot, so the old address then misses and the displaced address then hits. If `dsp_valid`=0 on a hit, the hit entry is emptied.
- R8: When the buffer is full, an insert replaces the least recently used entry. Both a hit and an insert make that entry the most recent.
- R9: In fetched-line mode (`CAPTURE_REQ`=1), the line from each memory response is stored. A hit leaves its entry valid and in place. Displaced lines are not stored.
- R10: When two line addresses that share one direct-mapped set are accessed alternately in displaced-line mode, every access after the first two is served as a buffer hit with the one-cycle penalty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Main-cache miss lookup request |
| lk_ready | output | 1 | Block can accept a lookup |
| lk_addr | input | ADDR_W | Missing line address |
| dsp_valid | input | 1 | Line being displaced from the main cache is valid |
| dsp_addr | input | ADDR_W | Displaced line address |
| dsp_data | input | LINE_W | Displaced line data |
| fill_valid | output | 1 | Refill line to the main cache is valid |
| fill_hit | output | 1 | Refill came from the buffer (1) or from memory (0) |
| fill_addr | output | ADDR_W | Refill line address |
| fill_data | output | LINE_W | Refill line data |
| mem_req | output | 1 | One-cycle request to the next level |
| mem_req_addr | output | ADDR_W | Requested line address |
| mem_rsp_valid | input | 1 | Next-level response valid |
| mem_rsp_data | input | LINE_W | Next-level response line |

## Verification
The assertions assume that the main cache never offers a displaced address that is already held in the buffer or that equals the lookup address. This is the exclusivity a real direct-mapped cache provides, and the no-duplicate check depends on it. They also assume that the next level answers only after its request cycle and only once per request. The stimulus respects both assumptions. It tracks a two-set cache model for the conflict sequence and picks fresh displaced addresses in the directed cases. The memory model answers a fixed three cycles after each request and never overlaps requests.

// File: rtl/conflict_victim_buf.sv
module conflict_victim_buf #(
  parameter int NUM_ENT     = 4,
  parameter int ADDR_W      = 26,
  parameter int LINE_W      = 64,
  parameter bit CAPTURE_REQ = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              dsp_valid,
  input  logic [ADDR_W-1:0] dsp_addr,
  input  logic [LINE_W-1:0] dsp_data,
  output logic              fill_valid,
  output logic              fill_hit,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [LINE_W-1:0] fill_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);
  localparam int RW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  logic [NUM_ENT-1:0] ent_v;
  logic [ADDR_W-1:0]  ent_tag  [NUM_ENT];
  logic [LINE_W-1:0]  ent_data [NUM_ENT];
  logic [RW-1:0]      ent_rank [NUM_ENT];

  logic               waiting;
  logic [NUM_ENT-1:0] match;
  logic               hit;
  logic [RW-1:0]      hit_idx, ins_idx, lru_idx;
  logic [LINE_W-1:0]  hit_data;
  logic               take, rsp_take;
  logic               wr_en, kill_en, touch_en;
  logic [RW-1:0]      wr_idx, touch_idx;
  logic [ADDR_W-1:0]  wr_tag;
  logic [LINE_W-1:0]  wr_data;
  logic               dup;

  assign lk_ready = !waiting;
  assign take     = lk_valid && lk_ready;
  assign rsp_take = waiting && !mem_req && mem_rsp_valid;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_cmp
    assign match[g] = ent_v[g] && (ent_tag[g] == lk_addr);
  end
  assign hit = |match;

  always_comb begin
    hit_idx  = '0;
    hit_data = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (match[i]) begin
        hit_idx  = RW'(i);
        hit_data = hit_data | ent_data[i];
      end
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < NUM_ENT; i++)
      if (ent_rank[i] == RW'(NUM_ENT - 1)) lru_idx = RW'(i);
    ins_idx = lru_idx;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (!ent_v[i]) ins_idx = RW'(i);
  end

  if (CAPTURE_REQ == 1'b0) begin : g_victim
    always_comb begin
      wr_en     = 1'b0;
      kill_en   = 1'b0;
      touch_en  = 1'b0;
      wr_idx    = ins_idx;
      touch_idx = ins_idx;
      wr_tag    = dsp_addr;
      wr_data   = dsp_data;
      if (take && hit) begin
        if (dsp_valid) begin
          wr_en     = 1'b1;
          wr_idx    = hit_idx;
          touch_en  = 1'b1;
          touch_idx = hit_idx;
        end else begin
          kill_en = 1'b1;
        end
      end else if (take && dsp_valid) begin
        wr_en    = 1'b1;
        touch_en = 1'b1;
      end
    end
  end else begin : g_capture
    always_comb begin
      wr_en     = rsp_take;
      kill_en   = 1'b0;
      touch_en  = rsp_take;
      wr_idx    = ins_idx;
      touch_idx = ins_idx;
      wr_tag    = mem_req_addr;
      wr_data   = mem_rsp_data;
      if (take && hit) begin
        touch_en  = 1'b1;
        touch_idx = hit_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
    end else if (wr_en) begin
      ent_v[wr_idx] <= 1'b1;
    end else if (kill_en) begin
      ent_v[hit_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_tag[wr_idx]  <= wr_tag;
      ent_data[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENT; i++) ent_rank[i] <= RW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < NUM_ENT; i++) begin
        if (RW'(i) == touch_idx)                 ent_rank[i] <= '0;
        else if (ent_rank[i] < ent_rank[touch_idx]) ent_rank[i] <= ent_rank[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting      <= 1'b0;
      mem_req      <= 1'b0;
      mem_req_addr <= '0;
      fill_valid   <= 1'b0;
      fill_hit     <= 1'b0;
      fill_addr    <= '0;
      fill_data    <= '0;
    end else begin
      mem_req    <= 1'b0;
      fill_valid <= 1'b0;
      if (take && hit) begin
        fill_valid <= 1'b1;
        fill_hit   <= 1'b1;
        fill_addr  <= lk_addr;
        fill_data  <= hit_data;
      end else if (take) begin
        waiting      <= 1'b1;
        mem_req      <= 1'b1;
        mem_req_addr <= lk_addr;
      end
      if (rsp_take) begin
        waiting    <= 1'b0;
        fill_valid <= 1'b1;
        fill_hit   <= 1'b0;
        fill_addr  <= mem_req_addr;
        fill_data  <= mem_rsp_data;
      end
    end
  end

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NUM_ENT; i++)
      for (int j = i + 1; j < NUM_ENT; j++)
        if (ent_v[i] && ent_v[j] && ent_tag[i] == ent_tag[j]) dup = 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ent_v == '0) && lk_ready && !fill_valid && !mem_req);
  p_unique_tag_r2: assert property (@(posedge clk) disable iff (!rst_n) !dup);
  p_hit_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take && hit |=> fill_valid && fill_hit && !mem_req && lk_ready);
  p_miss_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take && !hit |=> mem_req && (mem_req_addr == $past(lk_addr)) && !lk_ready && !fill_valid);
  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_rsp_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |=> fill_valid && !fill_hit && lk_ready);
  p_no_bad_insert_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && !hit && !dsp_valid |=> ent_v == $past(ent_v));
  p_swap_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !CAPTURE_REQ && take && hit && dsp_valid |=> $countones(ent_v) == $countones($past(ent_v)));
  p_capture_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    CAPTURE_REQ && take && hit |=> ent_v == $past(ent_v));
endmodule

// File: tb/sim_conflict_victim_buf.sv
module sim_conflict_victim_buf;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW = 26;
  localparam int LW = 64;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [LW-1:0] d;
    logic          h;
  } item_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          sel = 1'b0;
  logic          lk_v = 1'b0;
  logic [AW-1:0] lk_addr = '0;
  logic          dsp_v = 1'b0;
  logic [AW-1:0] dsp_addr = '0;
  logic [LW-1:0] dsp_data = '0;
  logic          rsp_v;
  logic [LW-1:0] rsp_data;

  logic          rdy0, fv0, fh0, mq0, rdy1, fv1, fh1, mq1;
  logic [AW-1:0] fa0, ma0, fa1, ma1;
  logic [LW-1:0] fd0, fd1;
  logic          lk_v0, lk_v1;
  logic          rdy, fv, fh, mq;
  logic [AW-1:0] fa, ma;
  logic [LW-1:0] fd;

  assign lk_v0 = lk_v && !sel;
  assign lk_v1 = lk_v && sel;
  assign rdy = sel ? rdy1 : rdy0;
  assign fv  = sel ? fv1 : fv0;
  assign fh  = sel ? fh1 : fh0;
  assign fa  = sel ? fa1 : fa0;
  assign fd  = sel ? fd1 : fd0;
  assign mq  = sel ? mq1 : mq0;
  assign ma  = sel ? ma1 : ma0;

  conflict_victim_buf #(.NUM_ENT(4), .ADDR_W(AW), .LINE_W(LW), .CAPTURE_REQ(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_v0), .lk_ready(rdy0), .lk_addr(lk_addr),
    .dsp_valid(dsp_v), .dsp_addr(dsp_addr), .dsp_data(dsp_data),
    .fill_valid(fv0), .fill_hit(fh0), .fill_addr(fa0), .fill_data(fd0),
    .mem_req(mq0), .mem_req_addr(ma0), .mem_rsp_valid(rsp_v), .mem_rsp_data(rsp_data));

  conflict_victim_buf #(.NUM_ENT(2), .ADDR_W(AW), .LINE_W(LW), .CAPTURE_REQ(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_v1), .lk_ready(rdy1), .lk_addr(lk_addr),
    .dsp_valid(dsp_v), .dsp_addr(dsp_addr), .dsp_data(dsp_data),
    .fill_valid(fv1), .fill_hit(fh1), .fill_addr(fa1), .fill_data(fd1),
    .mem_req(mq1), .mem_req_addr(ma1), .mem_rsp_valid(rsp_v), .mem_rsp_data(rsp_data));

  int n_run = 0;
  int n_fail = 0;
  item_t exp_q[$];
  logic          l1v [2];
  logic [AW-1:0] l1t [2];

  function automatic logic [LW-1:0] mdata(input logic [AW-1:0] a);
    return {6'h2A, a, 6'h15, ~a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // monitor: pops expected refills from the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (fv) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "refill with nothing expected", LW'(fa), '0);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          check(fa == e.a, e.h ? "R3" : "R4", "refill address", LW'(fa), LW'(e.a));
          check(fd == e.d, e.h ? "R3" : "R4", "refill data", fd, e.d);
          check(fh == e.h, e.h ? "R3" : "R4", "refill source", LW'(fh), LW'(e.h));
        end
      end
    end
  end

  // next-level memory: answers three cycles after a request
  initial begin
    int cnt;
    logic [AW-1:0] maddr;
    cnt = 0;
    maddr = '0;
    rsp_v = 1'b0;
    rsp_data = '0;
    forever begin
      @(negedge clk);
      rsp_v = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          rsp_v = 1'b1;
          rsp_data = mdata(maddr);
        end
      end else if (mq) begin
        maddr = ma;
        cnt = 3;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    exp_q.delete();
    l1v[0] = 1'b0;
    l1v[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // driver: pushes the expected refill, then runs one lookup
  task automatic lookup(input logic [AW-1:0] a, input bit dv, input logic [AW-1:0] da,
                        input logic [LW-1:0] dd, input bit eh, input logic [LW-1:0] ed,
                        input string req);
    item_t e;
    e.a = a;
    e.d = eh ? ed : mdata(a);
    e.h = eh;
    exp_q.push_back(e);
    @(negedge clk);
    lk_v = 1'b1;
    lk_addr = a;
    dsp_v = dv;
    dsp_addr = da;
    dsp_data = dd;
    @(negedge clk);
    lk_v = 1'b0;
    dsp_v = 1'b0;
    check(fv == eh, req, "refill one cycle after lookup", LW'(fv), LW'(eh));
    check(mq == !eh, req, "memory request", LW'(mq), LW'(!eh));
    if (!eh) begin
      check(ma == a, "R4", "request address", LW'(ma), LW'(a));
      check(!rdy, "R4", "busy while waiting", LW'(rdy), '0);
      while (!fv) @(negedge clk);
    end
  endtask

  // main-cache model with two sets, used for the R10 conflict sequence
  task automatic access(input logic [AW-1:0] a, input bit eh);
    int s;
    s = int'(a[0]);
    if (!(l1v[s] && l1t[s] == a)) begin
      lookup(a, l1v[s], l1t[s], mdata(l1t[s]), eh, mdata(a), "R10");
      l1v[s] = 1'b1;
      l1t[s] = a;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    check(rdy0 && rdy1, "R1", "ready after reset", LW'({rdy0, rdy1}), 64'h3);
    check(!fv0 && !fv1, "R1", "no refill after reset", LW'({fv0, fv1}), '0);
    check(!mq0 && !mq1, "R1", "no request after reset", LW'({mq0, mq1}), '0);
    lookup(26'h0000077, 1'b0, '0, '0, 1'b0, '0, "R1");

    // R10: two lines in set 0 accessed alternately
    do_reset();
    access(26'h0000010, 1'b0);
    access(26'h0000020, 1'b0);
    for (int k = 0; k < 8; k++)
      access((k % 2 == 0) ? 26'h0000010 : 26'h0000020, 1'b1);

    // R5, R6, R7, R2
    do_reset();
    lookup(26'h40, 1'b0, 26'h55, 64'h1, 1'b0, '0, "R6");
    lookup(26'h55, 1'b0, '0, '0, 1'b0, '0, "R6");
    lookup(26'h40, 1'b0, '0, '0, 1'b0, '0, "R5");
    lookup(26'h60, 1'b1, 26'h61, 64'hD1D1_0000_1111_2222, 1'b0, '0, "R5");
    lookup(26'h60, 1'b0, '0, '0, 1'b0, '0, "R5");
    lookup(26'h2000061, 1'b0, '0, '0, 1'b0, '0, "R2");
    lookup(26'h61, 1'b1, 26'h62, 64'hD2D2_3333_4444_5555, 1'b1, 64'hD1D1_0000_1111_2222, "R7");
    lookup(26'h61, 1'b0, '0, '0, 1'b0, '0, "R7");
    lookup(26'h62, 1'b0, '0, '0, 1'b1, 64'hD2D2_3333_4444_5555, "R7");
    lookup(26'h62, 1'b0, '0, '0, 1'b0, '0, "R7");

    // R8: least recently used replacement
    do_reset();
    for (int k = 1; k <= 4; k++)
      lookup(AW'(32'h200 + k), 1'b1, AW'(32'h100 + k), mdata(AW'(32'h100 + k)), 1'b0, '0, "R8");
    lookup(26'h101, 1'b1, 26'h111, mdata(26'h111), 1'b1, mdata(26'h101), "R8");
    lookup(26'h205, 1'b1, 26'h106, mdata(26'h106), 1'b0, '0, "R8");
    lookup(26'h102, 1'b0, '0, '0, 1'b0, '0, "R8");
    lookup(26'h103, 1'b0, '0, '0, 1'b1, mdata(26'h103), "R8");
    lookup(26'h104, 1'b0, '0, '0, 1'b1, mdata(26'h104), "R8");
    lookup(26'h111, 1'b0, '0, '0, 1'b1, mdata(26'h111), "R8");
    lookup(26'h106, 1'b0, '0, '0, 1'b1, mdata(26'h106), "R8");

    // R9: fetched-line mode on the second instance
    sel = 1'b1;
    do_reset();
    lookup(26'h300, 1'b1, 26'h301, 64'h5, 1'b0, '0, "R9");
    lookup(26'h301, 1'b0, '0, '0, 1'b0, '0, "R9");
    lookup(26'h300, 1'b1, 26'h333, 64'h6, 1'b1, mdata(26'h300), "R9");
    lookup(26'h300, 1'b0, '0, '0, 1'b1, mdata(26'h300), "R9");
    lookup(26'h333, 1'b0, '0, '0, 1'b0, '0, "R9");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R4", "all expected refills seen", LW'(exp_q.size()), '0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule